// File: doc/BRIEF.md
# Compare Match Interval Timer

This block is a bank of independent 16-bit interval timers that share one clock divider. Each channel counts prescaled clock enables. When the count has reached the channel's compare value, the next enabled tick reloads the counter to zero and sets a sticky match flag. The flag raises one of two level requests. A per-channel routing bit decides which one: a CPU interrupt line or a DMA request line. A DMA acknowledge for the channel clears the flag in hardware. Software clears it by writing zero to the flag bit.

Software reaches the channels over a small synchronous register bus. A write is a single-cycle strobe. A read returns the addressed register combinationally. The address is `{channel, register}`, where register 0 is control/status, 1 is the counter and 2 is the compare value.

Top module: `cmt_top`

## Requirements
- R1: After reset every request output is 0, and the control, counter and compare registers of every channel read 0.
- R2: The counter increments by one on each selected tick while the run bit (control bit 0) is 1. It holds its value while the run bit is 0. Control bits 2:1 select the tick period in system clocks: 0 gives 8, 1 gives 32, 2 gives 128, 3 gives 512.
- R3: Equality between the counter and the compare value alone does not set the flag. The next selected tick loads the counter with 0 and sets the flag (control bit 7) in the same clock. With compare value N, the flag therefore sets every (N+1) times the tick period. With N = 0 it sets on every tick.
- R4: The flag is sticky. A control write with bit 7 = 0 clears it, and a write with bit 7 = 1 leaves it unchanged. A match in the same cycle as a clear leaves the flag at 1.
- R5: The interrupt output of a channel is 1 exactly when, one clock earlier, its flag was 1, its enable (control bit 3) was 1 and its routing bit (control bit 4) was 0.
- R6: The DMA request of a channel is 1 exactly when, one clock earlier, its flag, enable and routing bit were all 1. A channel never drives its interrupt and its DMA request at the same time.
- R7: A one-cycle DMA acknowledge clears the channel's flag at that clock edge, unless a match sets it in the same cycle.
- R8: A write to the counter loads the written value even when a tick would have incremented it in the same cycle.
- R9: The channels are independent. Activity on one channel changes no output or register of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| bus_addr_i | input | CH_W+2 | Register address {channel, register} |
| bus_we_i | input | 1 | Single-cycle write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data of the addressed register |
| dma_ack_i | input | NUM_CH | Per-channel DMA transfer acknowledge |
| irq_o | output | NUM_CH | Per-channel CPU interrupt request |
| dma_req_o | output | NUM_CH | Per-channel DMA request |

## Verification
The assertions assume a DMA acknowledge arrives only for a channel whose DMA request is up. They also assume writes address existing channels and registers. The bench pulses an acknowledge only after it has seen the request high. It only addresses channel 0 or 1 at registers 0 to 2. It issues software clears right after a flag is seen, so a clear never coincides with a match unless a test intends it, and compare values are large enough to leave that gap. The timing checks measure the interval between two successive flag sets rather than an absolute time, so they do not depend on the phase of the shared divider.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int CNT_W     = 16;
  localparam int NUM_DIV   = 4;
  localparam int DIV_BASE  = 3;              // smallest divide is 2**3
  localparam int PRE_W     = DIV_BASE + 2 * (NUM_DIV - 1);

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_CMP   = 2'd2
  } reg_sel_e;

  localparam int RUN_BIT   = 0;
  localparam int SEL_LO    = 1;
  localparam int IEN_BIT   = 3;
  localparam int ROUTE_BIT = 4;
  localparam int FLAG_BIT  = 7;

  typedef struct packed {
    logic       flag;
    logic       route_dma;
    logic       irq_en;
    logic [1:0] clk_sel;
    logic       run;
  } ctrl_t;

  function automatic logic [CNT_W-1:0] pack_ctrl(input ctrl_t c);
    logic [CNT_W-1:0] w;
    w = '0;
    w[RUN_BIT]          = c.run;
    w[SEL_LO+1:SEL_LO]  = c.clk_sel;
    w[IEN_BIT]          = c.irq_en;
    w[ROUTE_BIT]        = c.route_dma;
    w[FLAG_BIT]         = c.flag;
    return w;
  endfunction

  // counter value after one tick: wrap to zero once compare was reached
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] cmp);
    return (cur == cmp) ? '0 : cur + 1'b1;
  endfunction

  // flag update: a set wins over any clear
  function automatic logic next_flag(input logic cur, input logic set,
                                     input logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
  import cmt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [NUM_DIV-1:0] tick_o
);
  logic [PRE_W-1:0] div_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_DIV; k++) begin : g_tick
    localparam int HI = DIV_BASE + 2 * k - 1;
    assign tick_o[k] = &div_q[HI:0];
  end

  // R2: a slower tick always coincides with the fastest one
  nested_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o[NUM_DIV-1] |-> tick_o[0]);
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_DIV-1:0] tick_i,
  input  logic               wr_ctrl_i,
  input  logic               wr_count_i,
  input  logic               wr_cmp_i,
  input  logic [CNT_W-1:0]   wdata_i,
  input  logic               dma_ack_i,
  output logic [CNT_W-1:0]   ctrl_o,
  output logic [CNT_W-1:0]   count_o,
  output logic [CNT_W-1:0]   cmp_o,
  output logic               irq_o,
  output logic               dma_req_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] count_q, cmp_q;
  logic             irq_q, dma_q;

  // named internal events
  logic step_evt, match_evt, sw_clr_evt, hw_clr_evt, req_level;

  assign step_evt   = ctrl_q.run & tick_i[ctrl_q.clk_sel] & ~wr_count_i;
  assign match_evt  = step_evt & (count_q == cmp_q);
  assign sw_clr_evt = wr_ctrl_i & ~wdata_i[FLAG_BIT];
  assign hw_clr_evt = dma_ack_i;
  assign req_level  = ctrl_q.flag & ctrl_q.irq_en;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      count_q <= '0;
      cmp_q   <= '0;
      irq_q   <= 1'b0;
      dma_q   <= 1'b0;
    end else begin
      if (wr_ctrl_i) begin
        ctrl_q.run       <= wdata_i[RUN_BIT];
        ctrl_q.clk_sel   <= wdata_i[SEL_LO+1:SEL_LO];
        ctrl_q.irq_en    <= wdata_i[IEN_BIT];
        ctrl_q.route_dma <= wdata_i[ROUTE_BIT];
      end
      ctrl_q.flag <= next_flag(ctrl_q.flag, match_evt, sw_clr_evt | hw_clr_evt);
      if (wr_count_i)    count_q <= wdata_i;
      else if (step_evt) count_q <= next_count(count_q, cmp_q);
      if (wr_cmp_i)      cmp_q <= wdata_i;
      irq_q <= req_level & ~ctrl_q.route_dma;
      dma_q <= req_level &  ctrl_q.route_dma;
    end
  end

  assign ctrl_o    = pack_ctrl(ctrl_q);
  assign count_o   = count_q;
  assign cmp_o     = cmp_q;
  assign irq_o     = irq_q;
  assign dma_req_o = dma_q;

  // R3
  match_wraps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_evt |=> (count_q == '0) && ctrl_q.flag);
  // R4
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.flag && !sw_clr_evt && !hw_clr_evt |=> ctrl_q.flag);
  // R2
  hold_when_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.run && !wr_count_i |=> $stable(count_q));
  // R6
  exclusive_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && dma_req_o));
  // R5
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(ctrl_q.flag) && !$past(ctrl_q.route_dma));
  // R7
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_clr_evt && !match_evt |=> !ctrl_q.flag);
  // R8
  count_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_count_i |=> count_q == $past(wdata_i));
endmodule

// File: rtl/cmt_top.sv
module cmt_top
  import cmt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int ADDR_W = CH_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  input  logic [NUM_CH-1:0] dma_ack_i,
  output logic [NUM_CH-1:0] irq_o,
  output logic [NUM_CH-1:0] dma_req_o
);
  logic [NUM_DIV-1:0] tick;
  logic [CH_W-1:0]    ch_sel;
  logic [1:0]         reg_sel;
  logic [CNT_W-1:0]   ctrl_rd  [NUM_CH];
  logic [CNT_W-1:0]   count_rd [NUM_CH];
  logic [CNT_W-1:0]   cmp_rd   [NUM_CH];

  assign ch_sel  = bus_addr_i[ADDR_W-1:2];
  assign reg_sel = bus_addr_i[1:0];

  cmt_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = bus_we_i && (ch_sel == CH_W'(c));
    cmt_channel u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick),
      .wr_ctrl_i  (hit && reg_sel == REG_CTRL),
      .wr_count_i (hit && reg_sel == REG_COUNT),
      .wr_cmp_i   (hit && reg_sel == REG_CMP),
      .wdata_i    (bus_wdata_i),
      .dma_ack_i  (dma_ack_i[c]),
      .ctrl_o     (ctrl_rd[c]),
      .count_o    (count_rd[c]),
      .cmp_o      (cmp_rd[c]),
      .irq_o      (irq_o[c]),
      .dma_req_o  (dma_req_o[c])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_sel == CH_W'(c)) begin
        case (reg_sel)
          REG_CTRL:  bus_rdata_o = ctrl_rd[c];
          REG_COUNT: bus_rdata_o = count_rd[c];
          REG_CMP:   bus_rdata_o = cmp_rd[c];
          default:   bus_rdata_o = '0;
        endcase
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (irq_o == '0) && (dma_req_o == '0));
endmodule

// File: tb/cmt_top_tb_top.sv
module cmt_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 2;
  localparam int AW = 3;

  typedef struct packed {
    logic [1:0]  sel;
    logic [15:0] cmp;
    logic [15:0] period;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{sel: 2'd0, cmp: 16'd0, period: 16'd8},
    '{sel: 2'd1, cmp: 16'd3, period: 16'd128},
    '{sel: 2'd2, cmp: 16'd1, period: 16'd256},
    '{sel: 2'd3, cmp: 16'd2, period: 16'd1536},
    '{sel: 2'd0, cmp: 16'd9, period: 16'd80}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [NUM_CH-1:0] ack = '0, irq, dreq;
  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmt_top #(.NUM_CH(NUM_CH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .dma_ack_i(ack),
    .irq_o(irq), .dma_req_o(dreq)
  );

  function automatic logic [15:0] cw(input logic run, input logic [1:0] sel,
                                     input logic ie, input logic rt, input logic fl);
    return {8'h00, fl, 2'b00, rt, ie, sel, run};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int r, input logic [15:0] d);
    @(negedge clk);
    addr = AW'({ch[0], r[1:0]}); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int ch, input int r, output logic [15:0] d);
    addr = AW'({ch[0], r[1:0]});
    #1 d = rdata;
  endtask

  task automatic wait_flag(input int ch, output int t);
    logic [15:0] v;
    int n;
    n = 0;
    forever begin
      @(negedge clk);
      rd(ch, 0, v);
      if (v[7]) break;
      n++;
      if (n > 20000) break;
    end
    t = cyc;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] v, v2;
    int t1, t2;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 irq", irq, 0);
    check("R1 dreq", dreq, 0);
    for (int r = 0; r < 3; r++) begin rd(0, r, v); check("R1 reg", v, 0); end
    rst_n = 1'b1;

    // R3 / R2: interval table
    for (int i = 0; i < 5; i++) begin
      wr(0, 0, cw(0, 0, 0, 0, 0));
      wr(0, 1, 16'd0);
      wr(0, 2, VECS[i].cmp);
      wr(0, 0, cw(1, VECS[i].sel, 1, 0, 0));
      wait_flag(0, t1);
      we = 1'b1; wdata = cw(1, VECS[i].sel, 1, 0, 0);
      @(negedge clk); we = 1'b0;
      wait_flag(0, t2);
      check("R3 period", t2 - t1, int'(VECS[i].period));
      // R9: other channel untouched
      check("R9 irq1", irq[1], 0);
    end

    // R3: equality alone does not set the flag
    wr(0, 0, cw(0, 0, 0, 0, 0));
    wr(0, 2, 16'd5);
    wr(0, 1, 16'd5);
    wr(0, 0, cw(1, 0, 0, 0, 0));
    rd(0, 1, v); check("R3 count held at cmp", v, 5);
    rd(0, 0, v); check("R3 flag not yet", v[7], 0);
    do begin @(negedge clk); rd(0, 1, v); end while (v == 16'd5);
    check("R3 wrap to zero", v, 0);
    rd(0, 0, v); check("R3 flag on wrap", v[7], 1);
    @(negedge clk);
    check("R5 irq off when disabled", irq[0], 0);

    // R4: sticky, write 1 no effect, write 0 clears
    wr(0, 2, 16'd400);
    wr(0, 0, cw(1, 0, 0, 0, 1));
    rd(0, 0, v); check("R4 write1 keeps flag", v[7], 1);
    repeat (20) @(negedge clk);
    rd(0, 0, v); check("R4 sticky", v[7], 1);
    wr(0, 0, cw(1, 0, 0, 0, 0));
    rd(0, 0, v); check("R4 write0 clears", v[7], 0);

    // R5: interrupt routing
    wr(0, 0, cw(0, 0, 0, 0, 0));
    wr(0, 1, 16'd0);
    wr(0, 2, 16'd50);
    wr(0, 0, cw(1, 0, 1, 0, 0));
    wait_flag(0, t1);
    @(negedge clk);
    check("R5 irq", irq[0], 1);
    check("R6 no dreq", dreq[0], 0);
    wr(0, 0, cw(1, 0, 1, 0, 0));
    @(negedge clk);
    check("R5 irq drops", irq[0], 0);

    // R6/R7: DMA routing and acknowledge
    wr(0, 0, cw(1, 0, 1, 1, 0));
    wait_flag(0, t1);
    @(negedge clk);
    check("R6 dreq", dreq[0], 1);
    check("R6 no irq", irq[0], 0);
    ack[0] = 1'b1;
    @(negedge clk);
    ack[0] = 1'b0;
    rd(0, 0, v); check("R7 ack clears flag", v[7], 0);
    @(negedge clk);
    check("R7 dreq drops", dreq[0], 0);

    // R8: counter writes every cycle while running
    wr(0, 2, 16'd1000);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      addr = AW'({1'b0, 2'd1}); wdata = 16'(100 + k); we = 1'b1;
      @(negedge clk);
      we = 1'b0;
      #1 check("R8 write wins", rdata, 100 + k);
    end

    // R2: stopped counter holds
    wr(0, 0, cw(0, 0, 0, 0, 0));
    rd(0, 1, v);
    repeat (40) @(negedge clk);
    rd(0, 1, v2); check("R2 hold", v2, v);

    // R9: channel 1 registers still at reset values
    rd(1, 1, v); check("R9 ch1 count", v, 0);
    rd(1, 0, v); check("R9 ch1 ctrl", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule